// File: doc/BRIEF.md
# Write Cycle Qualifier with Noise Filter

This block sits between an asynchronous, memory-style parallel bus and the synchronous logic behind it. It brings the three active-low control strobes (chip select, write strobe, read-drive enable) into the clock domain and decides whether a real write cycle took place. A write counts only when the bus shows the write combination: chip select low, write strobe low and read-drive enable high. That combination must hold for at least a programmable number of clock samples, so a short noise pulse on a strobe cannot start a write.

When a write qualifies, the address and data present on the bus are captured. Once both chip select and write strobe have returned high, the block raises a single-cycle write-valid pulse with the captured values beside it. After reset the block stays in a read-only state for a programmable settling period. It then needs both strobes to be seen high before it will accept any write, so a strobe that is already low when reset ends cannot produce a write. Command decoding and the storage array are outside this block.

Top module: `wr_qual_top`

## Requirements
- R1: After reset, `wr_valid` is 0. No write is reported for activity that starts during the first `SETTLE_CYC` cycles. No write is reported for a strobe that is held low across the end of that period, until both `cs_n` and `we_n` have been seen high.
- R2: With `cs_n`=0, `we_n`=0 and `rd_en_n`=1 held for at least `MIN_LOW` clock cycles, followed by `cs_n` and `we_n` both going high, exactly one `wr_valid` pulse is produced.
- R3: While `rd_en_n`=0 no write is reported, even if `cs_n` and `we_n` are both low.
- R4: A write combination that lasts fewer than `MIN_LOW` clock cycles produces no `wr_valid` pulse.
- R5: If `rd_en_n` falls to 0 after the write combination has qualified, and before the strobes return high, the write is dropped and no pulse is produced.
- R6: The pulse is issued only after the later of `cs_n` and `we_n` has risen. While one of them is still low, no pulse appears.
- R7: `wr_addr` and `wr_data` carry the address and data held on the bus during the qualified low phase, and they are valid in the same cycle as `wr_valid`.
- R8: `wr_valid` is never high for two consecutive cycles.
- R9: The overlap of the two strobes qualifies in the same way whichever of them falls first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Asynchronous chip select, active low |
| we_n | input | 1 | Asynchronous write strobe, active low |
| rd_en_n | input | 1 | Asynchronous read-drive enable, active low; low inhibits writes |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus write data |
| wr_valid | output | 1 | One-cycle pulse per qualified write |
| wr_addr | output | ADDR_W | Captured write address |
| wr_data | output | DATA_W | Captured write data |

## Verification
The bench builds the block with `MIN_LOW`=3, `SETTLE_CYC`=12, `SYNC_STAGES`=2, a 10-bit address and an 8-bit data bus. A minimum width of 3 puts the exact boundary in reach: low phases of 1 and 2 cycles must be rejected, and a 3-cycle low phase must be accepted. The short settling window lets one run cover a write attempted inside the window, a strobe held low across its end, and normal traffic afterwards. The two-stage synchroniser fixes the delay from a strobe edge to the qualifier, so the staggered-edge and early-release cases fall on known cycles.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [1:0] {
    QS_HOLD = 2'd0,
    QS_IDLE = 2'd1,
    QS_ARM  = 2'd2,
    QS_QUAL = 2'd3
  } qual_state_t;
endpackage

// File: rtl/wq_pipe.sv
module wq_pipe #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wq_settle.sv
module wq_settle #(
  parameter int SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  output logic settled
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      settled <= 1'b0;
    end else if (!settled) begin
      if (cnt_q == CNT_W'(SETTLE_CYC - 1)) settled <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wq_qual.sv
module wq_qual
  import wq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int MIN_LOW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              settled,
  input  logic              cs_s,
  input  logic              we_s,
  input  logic              rd_s,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] data_d,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int   CNT_W    = $clog2(MIN_LOW + 1);
  localparam logic ONE_SHOT = (MIN_LOW <= 1);

  qual_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_cond;
  logic             released;

  // write combination seen in the clock domain, only once settled
  assign wr_cond  = settled & ~cs_s & ~we_s & rd_s;
  assign released = cs_s & we_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= QS_HOLD;
      cnt_q    <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      case (state_q)
        QS_HOLD: begin
          if (settled && released) state_q <= QS_IDLE;
        end
        QS_IDLE: begin
          if (wr_cond) begin
            if (ONE_SHOT) begin
              state_q <= QS_QUAL;
              wr_addr <= addr_d;
              wr_data <= data_d;
            end else begin
              state_q <= QS_ARM;
              cnt_q   <= CNT_W'(1);
            end
          end
        end
        QS_ARM: begin
          if (!wr_cond) begin
            state_q <= QS_HOLD;
          end else if (cnt_q == CNT_W'(MIN_LOW - 1)) begin
            state_q <= QS_QUAL;
            wr_addr <= addr_d;
            wr_data <= data_d;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        QS_QUAL: begin
          if (!rd_s) begin
            state_q <= QS_HOLD;
          end else if (released) begin
            wr_valid <= 1'b1;
            state_q  <= QS_IDLE;
          end
        end
        default: state_q <= QS_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/wr_qual_top.sv
module wr_qual_top #(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4,
  parameter int SETTLE_CYC  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              rd_en_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [2:0]       ctl_s;
  logic             cs_s;
  logic             we_s;
  logic             rd_s;
  logic             settled;
  logic [BUS_W-1:0] bus_d;

  // control strobes: synchroniser, idle value high
  wq_pipe #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .din ({cs_n, we_n, rd_en_n}),
    .dout(ctl_s)
  );

  // address/data delayed to line up with the strobes
  wq_pipe #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_dly (
    .clk (clk),
    .rst (rst),
    .din ({bus_addr, bus_data}),
    .dout(bus_d)
  );

  assign cs_s = ctl_s[2];
  assign we_s = ctl_s[1];
  assign rd_s = ctl_s[0];

  wq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .settled(settled)
  );

  wq_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW(MIN_LOW)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .settled (settled),
    .cs_s    (cs_s),
    .we_s    (we_s),
    .rd_s    (rd_s),
    .addr_d  (bus_d[BUS_W-1:DATA_W]),
    .data_d  (bus_d[DATA_W-1:0]),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );
endmodule

// File: rtl/wr_qual_chk.sv
module wr_qual_chk (
  input logic clk,
  input logic rst,
  input logic settled,
  input logic cs_s,
  input logic we_s,
  input logic rd_s,
  input logic wr_valid
);
  AST_NO_PULSE_UNSETTLED: assert property (@(posedge clk) disable iff (rst)
    !settled |-> !wr_valid); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R8

  AST_READ_INHIBITS: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> $past(rd_s)); // R3

  AST_BOTH_RELEASED: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> $past(cs_s && we_s)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !wr_valid); // R1
endmodule

bind wr_qual_top wr_qual_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .settled (settled),
  .cs_s    (cs_s),
  .we_s    (we_s),
  .rd_s    (rd_s),
  .wr_valid(wr_valid)
);

// File: tb/wr_qual_top_tb_top.sv
module wr_qual_top_tb_top;
  localparam int AW   = 10;
  localparam int DW   = 8;
  localparam int MINL = 3;
  localparam int SETL = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          we_n = 1'b1;
  logic          rd_en_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_vec  = 0;
  int n_fail = 0;
  int n_pulse = 0;
  bit done = 1'b0;

  logic [AW+DW-1:0] exp_q [$];
  string            tag_q [$];

  always #5 clk = ~clk;

  wr_qual_top #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
                .MIN_LOW(MINL), .SETTLE_CYC(SETL)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .rd_en_n(rd_en_n),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every pulse must match the oldest expected write (R2, R7)
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      n_pulse++;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected write: actual addr=%0h data=%0h expected none",
                 wr_addr, wr_data);
      end else begin
        logic [AW+DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          n_fail++;
          $display("FAIL %s R7 capture: actual %0h/%0h expected %0h/%0h",
                   t, wr_addr, wr_data, e[AW+DW-1:DW], e[DW-1:0]);
        end
      end
    end
  end

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string t);
    exp_q.push_back({a, d});
    tag_q.push_back(t);
  endtask

  task automatic check_drained(input string t);
    cyc(6);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s pending writes: actual %0d expected 0", t, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // both strobes fall and rise together
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int low_len, input bit exp, input string t);
    bus_addr = a;
    bus_data = d;
    rd_en_n  = 1'b1;
    cyc(1);
    cs_n = 1'b0;
    we_n = 1'b0;
    if (exp) expect_wr(a, d, t);
    cyc(low_len);
    cs_n = 1'b1;
    we_n = 1'b1;
    cyc(3);
  endtask

  initial begin
    int base;
    cyc(3);
    n_vec++;
    if (wr_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual wr_valid=%b expected 0", wr_valid);
    end
    rst = 1'b0;
    // R1: write attempted inside the settling window
    cyc(1);
    do_write(10'h055, 8'h11, 5, 1'b0, "R1");
    cyc(SETL);
    check_drained("R1 settle window");

    // R2 / R7: ordinary writes of several lengths and patterns
    do_write(10'h3ff, 8'hff, 3, 1'b1, "R2 len3");
    do_write(10'h000, 8'h00, 5, 1'b1, "R2 len5");
    do_write(10'h2a5, 8'h5a, 9, 1'b1, "R7 len9");
    check_drained("R2 basic");

    // R2: back-to-back with a single high cycle between
    bus_addr = 10'h101; bus_data = 8'h3c;
    cyc(1);
    cs_n = 0; we_n = 0; expect_wr(10'h101, 8'h3c, "R2 b2b first");
    cyc(4);
    cs_n = 1; we_n = 1;
    cyc(1);
    bus_addr = 10'h202; bus_data = 8'hc3;
    cs_n = 0; we_n = 0; expect_wr(10'h202, 8'hc3, "R2 b2b second");
    cyc(4);
    cs_n = 1; we_n = 1;
    check_drained("R2 back-to-back");

    // R4: glitches below the minimum width
    do_write(10'h011, 8'h01, 1, 1'b0, "R4 len1");
    do_write(10'h022, 8'h02, 2, 1'b0, "R4 len2");
    check_drained("R4 glitch");
    base = n_pulse;
    n_vec++;
    if (n_pulse != base) n_fail++;

    // R3: read-drive enable low inhibits
    base = n_pulse;
    rd_en_n = 0; bus_addr = 10'h033; bus_data = 8'h03;
    cyc(1);
    cs_n = 0; we_n = 0;
    cyc(8);
    cs_n = 1; we_n = 1;
    cyc(4);
    rd_en_n = 1;
    cyc(4);
    n_vec++;
    if (n_pulse != base) begin
      n_fail++;
      $display("FAIL R3 inhibit: actual %0d pulses expected 0", n_pulse - base);
    end

    // R5: read-drive enable falls after qualification
    base = n_pulse;
    bus_addr = 10'h044; bus_data = 8'h04;
    cyc(1);
    cs_n = 0; we_n = 0;
    cyc(6);
    rd_en_n = 0;
    cyc(2);
    cs_n = 1; we_n = 1;
    cyc(3);
    rd_en_n = 1;
    cyc(4);
    n_vec++;
    if (n_pulse != base) begin
      n_fail++;
      $display("FAIL R5 abort: actual %0d pulses expected 0", n_pulse - base);
    end

    // R6: chip select released first, write strobe later
    base = n_pulse;
    bus_addr = 10'h066; bus_data = 8'h66;
    cyc(1);
    cs_n = 0; we_n = 0;
    expect_wr(10'h066, 8'h66, "R6 late release");
    cyc(5);
    cs_n = 1;
    cyc(6);
    n_vec++;
    if (n_pulse != base) begin
      n_fail++;
      $display("FAIL R6 early commit: actual %0d pulses expected 0", n_pulse - base);
    end
    we_n = 1;
    check_drained("R6 late release");

    // R9: write strobe first, chip select later, overlap 3
    bus_addr = 10'h077; bus_data = 8'h77;
    cyc(1);
    we_n = 0;
    cyc(2);
    cs_n = 0; expect_wr(10'h077, 8'h77, "R9 staggered");
    cyc(3);
    we_n = 1;
    cyc(1);
    cs_n = 1;
    check_drained("R9 staggered ok");
    // R9: chip select first, overlap only 2
    bus_addr = 10'h088; bus_data = 8'h88;
    cyc(1);
    cs_n = 0;
    cyc(3);
    we_n = 0;
    cyc(2);
    we_n = 1;
    cyc(2);
    cs_n = 1;
    check_drained("R9 staggered short");

    // R1: strobes held low across reset and settling
    base = n_pulse;
    rst = 1;
    cs_n = 0; we_n = 0;
    cyc(3);
    rst = 0;
    cyc(SETL + 6);
    cs_n = 1; we_n = 1;
    cyc(6);
    n_vec++;
    if (n_pulse != base) begin
      n_fail++;
      $display("FAIL R1 held low: actual %0d pulses expected 0", n_pulse - base);
    end
    do_write(10'h099, 8'h99, 4, 1'b1, "R1 after hold");
    check_drained("R1 after hold");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule